// File: doc/BRIEF.md
# Per-PC Access Correlation Trainer

This block watches the stream of demand accesses reaching a cache and, for every instruction address (PC) it has seen, remembers the cache block that instruction touched most recently together with the security state of that access. When the same PC issues another access in the same security state, the block emits an ordered pair: the earlier block as A and the new block as B. A downstream address linearizer consumes these pairs as temporal correlations. Because the pairs follow each PC's own history, they capture irregular sequences such as pointer chasing, not just constant strides.

The table is fully associative. Each access that carries a PC either hits an existing entry or allocates the least recently used one, and afterwards the entry holds the current block. Accesses without a PC are dropped before they reach the table. All outputs are registered and appear one clock after the request. The last-address storage is a single write port and a synchronous read port, so it can map onto block RAM. Tags, security bits, valid bits and ages are kept in flip-flops for the parallel compare.

Top module: `pcct_top`

## Requirements
- R1: A request with `req_valid` low, or with `req_pc_valid` low, has no effect: no pair is emitted for it and no table entry or age changes.
- R2: The byte address is reduced to a block index by dropping its low `BLK_OFF` bits before it is stored or compared. Two addresses in the same block are the same block, and `pair_a` and `pair_b` carry block indices.
- R3: A lookup hits only when an entry is valid, its PC equals `req_pc`, and its stored secure bit equals `req_sec`. The same PC in the other security state misses and gets its own entry.
- R4: On a hit, one clock after the request `pair_valid` is 1, `pair_a` is the block last recorded for that PC and security state, `pair_b` is the current block, and `pair_sec` is `req_sec`.
- R5: On a miss, `pair_valid` is 0 one clock after the request, and an entry is allocated and tagged with the PC and secure bit.
- R6: After a hit or a miss, the entry's stored block is the current block, so the next hit for that PC reports it as A.
- R7: When the table is full, a miss replaces the entry used least recently. Both hits and allocations count as uses.
- R8: After reset all entries are invalid, `pair_valid` is 0, and the first access from any PC misses.
- R9: `pair_valid` is 1 for exactly one clock for each hitting request and is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_pc_valid | input | 1 | The access carries an instruction address |
| req_pc | input | PC_W | Instruction address of the access |
| req_addr | input | ADDR_W | Byte address of the access |
| req_sec | input | 1 | Access belongs to the secure space |
| pair_valid | output | 1 | A correlated pair is presented |
| pair_a | output | ADDR_W-BLK_OFF | Earlier block of the pair |
| pair_b | output | ADDR_W-BLK_OFF | Later (current) block of the pair |
| pair_sec | output | 1 | Security state of the pair |

## Verification
The bench builds the block with 4 entries, 16-bit PCs, 32-bit addresses and 64-byte blocks. With only four entries a handful of PCs fills the table, so replacement order, refresh by hits, and eviction of the secure and non-secure twins of one PC all come up in short directed sequences. A long random stream over six PCs and both security states then keeps the table in constant eviction while the cycle-by-cycle reference model tracks use order.

// File: rtl/pcct_pkg.sv
package pcct_pkg;
  // outcome of one table lookup
  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_HIT  = 2'd1,
    LK_MISS = 2'd2
  } lookup_e;
endpackage

// File: rtl/pcct_match.sv
module pcct_match #(
  parameter int ENTRIES = 128,
  parameter int PC_W    = 32,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0]           ent_vld,
  input  logic [ENTRIES-1:0][PC_W-1:0] ent_pc,
  input  logic [ENTRIES-1:0]           ent_sec,
  input  logic [PC_W-1:0]              key_pc,
  input  logic                         key_sec,
  output logic [ENTRIES-1:0]           hit_oh,
  output logic                         hit,
  output logic [IDX_W-1:0]             hit_idx
);
  // parallel compare, one comparator per entry
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_oh[g] = ent_vld[g] && (ent_pc[g] == key_pc) && (ent_sec[g] == key_sec);
  end

  assign hit = |hit_oh;

  // one-hot to binary by OR-reduction of index bits
  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_oh[i]) hit_idx = hit_idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/pcct_lru.sv
module pcct_lru #(
  parameter int ENTRIES = 128,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               touch,
  input  logic [IDX_W-1:0]   touch_idx,
  output logic [ENTRIES-1:0] victim_oh,
  output logic [IDX_W-1:0]   victim_idx
);
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

  // ages form a permutation of 0..ENTRIES-1; 0 is most recent
  logic [IDX_W-1:0] age [ENTRIES];
  logic [IDX_W-1:0] ref_age;

  assign ref_age = age[touch_idx];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_age
    always_ff @(posedge clk) begin
      if (rst) begin
        age[g] <= IDX_W'(g);
      end else if (touch) begin
        if (touch_idx == IDX_W'(g)) age[g] <= '0;
        else if (age[g] < ref_age)  age[g] <= age[g] + 1'b1;
      end
    end
    assign victim_oh[g] = (age[g] == OLDEST);
  end

  always_comb begin
    victim_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (victim_oh[i]) victim_idx = victim_idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/pcct_addr_ram.sv
module pcct_addr_ram #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 26,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  // simple dual port, read-before-write on a shared address
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pcct_top.sv
module pcct_top #(
  parameter int ENTRIES = 128,
  parameter int PC_W    = 32,
  parameter int ADDR_W  = 32,
  parameter int BLK_OFF = 6,
  localparam int BLK_W  = ADDR_W - BLK_OFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_pc_valid,
  input  logic [PC_W-1:0]   req_pc,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_sec,
  output logic              pair_valid,
  output logic [BLK_W-1:0]  pair_a,
  output logic [BLK_W-1:0]  pair_b,
  output logic              pair_sec
);
  import pcct_pkg::*;

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]           ent_vld;
  logic [ENTRIES-1:0][PC_W-1:0] ent_pc;
  logic [ENTRIES-1:0]           ent_sec;

  logic [ENTRIES-1:0] hit_oh;
  logic [ENTRIES-1:0] victim_oh;
  logic               hit;
  logic [IDX_W-1:0]   hit_idx;
  logic [IDX_W-1:0]   victim_idx;
  logic [IDX_W-1:0]   sel_idx;
  logic [BLK_W-1:0]   cur_blk;
  logic               access;
  lookup_e            outcome;

  assign access  = req_valid && req_pc_valid;
  assign cur_blk = req_addr[ADDR_W-1:BLK_OFF];

  pcct_match #(.ENTRIES(ENTRIES), .PC_W(PC_W)) match_i (
    .ent_vld (ent_vld),
    .ent_pc  (ent_pc),
    .ent_sec (ent_sec),
    .key_pc  (req_pc),
    .key_sec (req_sec),
    .hit_oh  (hit_oh),
    .hit     (hit),
    .hit_idx (hit_idx)
  );

  always_comb begin
    if (!access)  outcome = LK_IDLE;
    else if (hit) outcome = LK_HIT;
    else          outcome = LK_MISS;
  end

  assign sel_idx = (outcome == LK_HIT) ? hit_idx : victim_idx;

  pcct_lru #(.ENTRIES(ENTRIES)) lru_i (
    .clk        (clk),
    .rst        (rst),
    .touch      (access),
    .touch_idx  (sel_idx),
    .victim_oh  (victim_oh),
    .victim_idx (victim_idx)
  );

  // tag, security and valid state
  always_ff @(posedge clk) begin
    if (rst) begin
      ent_vld <= '0;
      ent_pc  <= '0;
      ent_sec <= '0;
    end else if (access) begin
      ent_vld[sel_idx] <= 1'b1;
      ent_pc[sel_idx]  <= req_pc;
      ent_sec[sel_idx] <= req_sec;
    end
  end

  // last block per entry; read of the old value doubles as output A
  pcct_addr_ram #(.DEPTH(ENTRIES), .DATA_W(BLK_W)) last_i (
    .clk   (clk),
    .we    (access),
    .waddr (sel_idx),
    .wdata (cur_blk),
    .raddr (hit_idx),
    .rdata (pair_a)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pair_valid <= 1'b0;
      pair_b     <= '0;
      pair_sec   <= 1'b0;
    end else begin
      pair_valid <= (outcome == LK_HIT);
      pair_b     <= cur_blk;
      pair_sec   <= req_sec;
    end
  end
endmodule

// File: rtl/pcct_chk.sv
module pcct_chk #(
  parameter int ENTRIES = 128,
  parameter int ADDR_W  = 32,
  parameter int BLK_OFF = 6
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      req_valid,
  input logic                      req_pc_valid,
  input logic [ADDR_W-1:0]         req_addr,
  input logic                      req_sec,
  input logic                      pair_valid,
  input logic [ADDR_W-BLK_OFF-1:0] pair_b,
  input logic                      pair_sec,
  input logic [ENTRIES-1:0]        hit_oh,
  input logic [ENTRIES-1:0]        victim_oh
);
  a_r1_no_pair_without_pc: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_pc_valid) |=> !pair_valid);

  a_r4_b_is_current_block: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_pc_valid) |=>
      (!pair_valid || pair_b == $past(req_addr[ADDR_W-1:BLK_OFF])));

  a_r4_sec_follows_request: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_pc_valid) |=> (!pair_valid || pair_sec == $past(req_sec)));

  a_r3_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_oh));

  a_r7_single_victim: assert property (@(posedge clk) disable iff (rst)
    $countones(victim_oh) == 1);

  a_r8_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> !pair_valid);
endmodule

bind pcct_top pcct_chk #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .BLK_OFF(BLK_OFF)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_pc_valid (req_pc_valid),
  .req_addr     (req_addr),
  .req_sec      (req_sec),
  .pair_valid   (pair_valid),
  .pair_b       (pair_b),
  .pair_sec     (pair_sec),
  .hit_oh       (hit_oh),
  .victim_oh    (victim_oh)
);

// File: tb/pcct_top_tb_top.sv
`timescale 1ns/1ps
module pcct_top_tb_top;
  localparam int N    = 4;
  localparam int PCW  = 16;
  localparam int AW   = 32;
  localparam int OFF  = 6;
  localparam int BW   = AW - OFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_pc_valid = 1'b0, req_sec = 1'b0;
  logic [PCW-1:0] req_pc = '0;
  logic [AW-1:0]  req_addr = '0;
  logic           pair_valid, pair_sec;
  logic [BW-1:0]  pair_a, pair_b;

  always #2.5 clk = ~clk;

  pcct_top #(.ENTRIES(N), .PC_W(PCW), .ADDR_W(AW), .BLK_OFF(OFF)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_pc_valid(req_pc_valid),
    .req_pc(req_pc), .req_addr(req_addr), .req_sec(req_sec),
    .pair_valid(pair_valid), .pair_a(pair_a), .pair_b(pair_b), .pair_sec(pair_sec)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference: list ordered most recent first
  int          m_pc[$];
  bit          m_sec[$];
  logic [BW-1:0] m_last[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one request; result compared on the following negative edge
  task automatic step(input bit v, input bit pv, input int pc, input logic [AW-1:0] addr,
                      input bit sec, input string req);
    bit ev = 0;
    logic [BW-1:0] ea = '0, eb;
    req_valid = v; req_pc_valid = pv; req_pc = PCW'(pc); req_addr = addr; req_sec = sec;
    eb = addr[AW-1:OFF];
    if (v && pv) begin
      int f = -1;
      foreach (m_pc[i]) if (f < 0 && m_pc[i] == pc && m_sec[i] == sec) f = i;
      if (f >= 0) begin
        ev = 1; ea = m_last[f];
        m_pc.delete(f); m_sec.delete(f); m_last.delete(f);
      end else if (m_pc.size() == N) begin
        void'(m_pc.pop_back()); void'(m_sec.pop_back()); void'(m_last.pop_back());
      end
      m_pc.push_front(pc); m_sec.push_front(sec); m_last.push_front(eb);
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; req_pc_valid = 0;
    check(pair_valid == ev, req, "pair_valid", pair_valid, ev);
    if (ev) begin
      check(pair_a == ea, req, "pair_a", pair_a, ea);
      check(pair_b == eb, req, "pair_b", pair_b, eb);
      check(pair_sec == sec, req, "pair_sec", pair_sec, sec);
    end
  endtask

  task automatic do_reset();
    rst = 1;
    m_pc.delete(); m_sec.delete(); m_last.delete();
    repeat (2) @(negedge clk);
    rst = 0;
    check(pair_valid == 0, "R8", "pair_valid after reset", pair_valid, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // first access always misses
    step(1, 1, 10, 32'h0000_1000, 0, "R8");
    // same block, different offset: A == B == 0x40
    step(1, 1, 10, 32'h0000_1010, 0, "R2");
    step(1, 1, 10, 32'h0000_2000, 0, "R4");
    // other security state of same PC misses
    step(1, 1, 10, 32'h0000_3000, 1, "R3");
    step(1, 1, 10, 32'h0000_4000, 0, "R6");
    step(1, 1, 10, 32'h0000_5000, 1, "R3");
    // accesses without PC or without valid must not alter state
    step(1, 0, 10, 32'h0000_9000, 0, "R1");
    step(0, 1, 10, 32'h0000_A000, 0, "R1");
    step(1, 1, 10, 32'h0000_6000, 0, "R1");
    // pulse lasts a single cycle
    step(0, 0, 0, 32'h0, 0, "R9");

    // replacement order
    do_reset();
    for (int p = 1; p <= 4; p++) step(1, 1, p, 32'h100 * p, 0, "R5");
    step(1, 1, 1, 32'h0001_0000, 0, "R7");   // refresh PC 1
    step(1, 1, 5, 32'h0002_0000, 0, "R5");   // evicts PC 2
    step(1, 1, 2, 32'h0003_0000, 0, "R7");   // must miss
    step(1, 1, 1, 32'h0004_0000, 0, "R7");   // must still hit
    step(1, 1, 3, 32'h0005_0000, 0, "R7");   // evicted by PC 2 insert

    // random traffic with mid-run reset
    for (int k = 0; k < 4000; k++) begin
      if (k == 2000) do_reset();
      step(($urandom % 8) != 0, ($urandom % 6) != 0, int'($urandom % 6),
           $urandom, bit'($urandom % 2), "R4");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule